// File: doc/BRIEF.md
# Multispeed data-strobe serializer/deserializer

This block sits between the link-side parallel data path of a serial-bus physical layer and one cable port. On the transmit side it takes a word once per system period, marked by a one-cycle `sys_tick` in the bit-clock domain. At the lowest speed it uses 2 bits of the word, at the middle speed 4 and at the top speed 8. It sends these bits most significant first as a data line and a strobe line. The strobe changes whenever the data does not, so exactly one of the two lines moves per bit. Data leaves on pair B and strobe on pair A.

On receive, data arrives on pair A and strobe on pair B. Each change of A XOR B marks a new bit, whose value is read from A. Every decoded bit goes straight out on a repeat port so it can be forwarded to other ports. The bits are also packed into 2, 4 or 8 bit words according to the receive speed, left-justified in an 8-bit field. A small dual-clock FIFO with Gray-coded pointers carries these words into the system clock domain. The speed in each direction is captured when the packet starts and stays fixed until the packet ends.

Top module: `ds_serdes`

## Requirements
- R1: After reset, `tx_pair_a`, `tx_pair_b`, `tx_drive`, `rep_valid` and `rx_valid` are all 0.
- R2: Speed code 0 sends `tx_data[7:6]`, code 1 sends `tx_data[7:4]`, and codes 2 and 3 send all of `tx_data[7:0]`. The word is captured on a `clk_bit` edge where `sys_tick` is 1 and `tx_en` is 1, and the unused low bits have no effect on the lines.
- R3: Bits go out most significant first on `tx_pair_b`. The first bit appears after the capturing edge, and the following bits come every 4, 2 or 1 `clk_bit` cycles for codes 0, 1 and 2/3. A word's last bit is sent before the next tick.
- R4: `tx_pair_a` (strobe) toggles for a bit exactly when that bit equals the previous data bit. A packet starts from data 0 and strobe 0.
- R5: The transmit speed is taken from `tx_speed` at the tick that starts a packet, and changes of `tx_speed` while the packet runs are ignored.
- R6: A tick with `tx_en` at 0 ends the packet: both transmit lines return to 0 and `tx_drive` falls.
- R7: `tx_drive` is 1 only while a transmit packet is active and `rx_en` is 0.
- R8: While `rx_en` is 1, each change of `rx_pair_a` XOR `rx_pair_b` yields one decoded bit equal to `rx_pair_a`. That bit is presented on `rep_bit` with `rep_valid` high for one `clk_bit` cycle, two cycles after the lines change.
- R9: Decoded bits are grouped, first bit most significant, into words of 2, 4 or 8 bits for `rx_speed` codes 0, 1 and 2/3. Each word is left-justified in `rx_word` with zero fill below.
- R10: Bits of an incomplete word still pending when `rx_en` falls are discarded.
- R11: The receive speed is taken from `rx_speed` when `rx_en` rises, and later changes during the packet are ignored.
- R12: Completed words appear in the `clk_sys` domain in arrival order, each as one cycle of `rx_valid` with the word on `rx_word`, through a 4-entry FIFO that is never written while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock, one cycle per top-speed bit |
| clk_sys | input | 1 | System clock for received words |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | input | 1 | One `clk_bit` cycle per system period; transmit word boundary |
| tx_en | input | 1 | Packet transmit request, sampled at ticks |
| tx_speed | input | 2 | Transmit speed code (0 low, 1 middle, 2/3 top) |
| tx_data | input | 8 | Transmit word, significant bits left-justified |
| tx_pair_a | output | 1 | Encoded strobe line (pair A) |
| tx_pair_b | output | 1 | Encoded data line (pair B) |
| tx_drive | output | 1 | Transmitter enable for the port |
| rx_en | input | 1 | Receive packet present |
| rx_speed | input | 2 | Receive speed code (0 low, 1 middle, 2/3 top) |
| rx_pair_a | input | 1 | Received data line (pair A) |
| rx_pair_b | input | 1 | Received strobe line (pair B) |
| rep_valid | output | 1 | Decoded bit available for repeating |
| rep_bit | output | 1 | Decoded bit value |
| rx_valid | output | 1 | Received word valid in `clk_sys` domain |
| rx_word | output | 8 | Received word, left-justified |

## Verification
The hardest situation to reach is a speed change in the middle of a packet, in either direction, combined with transmit and receive overlapping on the same port. The stimulus sends a top-speed receive packet and moves `rx_speed` to the lowest code after a few bits. It also changes `tx_speed` between ticks of a running packet. Separately, it starts a receive packet while a transmit packet is in flight, so the drive enable must fall while the serializer keeps advancing. A receive packet that ends two bits into a word checks that the partial word never reaches the FIFO.

// File: rtl/ds_pkg.sv
package ds_pkg;
  typedef enum logic [1:0] {
    SPD_LOW  = 2'd0,
    SPD_MID  = 2'd1,
    SPD_TOP  = 2'd2,
    SPD_TOPX = 2'd3
  } spd_e;
endpackage

// File: rtl/ds_tx.sv
module ds_tx
  import ds_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int PW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  spd_e              spd_in,
  input  logic [WORD_W-1:0] word,
  output logic              line_data,
  output logic              line_strobe,
  output logic              active,
  output spd_e              spd,
  output logic [PW-1:0]     rem
);

  logic [PW-1:0]     ph_q, ph_d, rem_q, rem_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              act_q, act_d, dat_q, dat_d, stb_q, stb_d;
  logic              bit_en, nbit;
  spd_e              spd_q, spd_d, sp;

  function automatic logic [PW-1:0] last_idx(input spd_e s);
    case (s)
      SPD_LOW: return PW'(WORD_W / 4 - 1);
      SPD_MID: return PW'(WORD_W / 2 - 1);
      default: return PW'(WORD_W - 1);
    endcase
  endfunction

  always_comb begin
    ph_d = tick ? PW'(1) : ph_q + PW'(1);
    case (spd_q)
      SPD_LOW: bit_en = (ph_q[1:0] == 2'b00);
      SPD_MID: bit_en = ~ph_q[0];
      default: bit_en = 1'b1;
    endcase
    sp    = act_q ? spd_q : spd_in;
    act_d = act_q;
    spd_d = spd_q;
    sh_d  = sh_q;
    rem_d = rem_q;
    dat_d = dat_q;
    stb_d = stb_q;
    nbit  = 1'b0;
    if (tick) begin
      if (en) begin
        act_d = 1'b1;
        spd_d = sp;
        nbit  = word[WORD_W-1];
        sh_d  = word << 1;
        rem_d = last_idx(sp);
        stb_d = stb_q ^ (nbit == dat_q);
        dat_d = nbit;
      end else begin
        act_d = 1'b0;
        sh_d  = '0;
        rem_d = '0;
        dat_d = 1'b0;
        stb_d = 1'b0;
      end
    end else if (act_q && bit_en && (rem_q != '0)) begin
      nbit  = sh_q[WORD_W-1];
      sh_d  = sh_q << 1;
      rem_d = rem_q - PW'(1);
      stb_d = stb_q ^ (nbit == dat_q);
      dat_d = nbit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      rem_q <= '0;
      sh_q  <= '0;
      act_q <= 1'b0;
      dat_q <= 1'b0;
      stb_q <= 1'b0;
      spd_q <= SPD_LOW;
    end else begin
      ph_q  <= ph_d;
      rem_q <= rem_d;
      sh_q  <= sh_d;
      act_q <= act_d;
      dat_q <= dat_d;
      stb_q <= stb_d;
      spd_q <= spd_d;
    end
  end

  assign line_data   = dat_q;
  assign line_strobe = stb_q;
  assign active      = act_q;
  assign spd         = spd_q;
  assign rem         = rem_q;

endmodule

// File: rtl/ds_rx.sv
module ds_rx
  import ds_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int PW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  spd_e              spd_in,
  input  logic              line_a,
  input  logic              line_b,
  output logic              rep_valid,
  output logic              rep_bit,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);

  logic              a_q, b_q, on_q, px_q, px_d, rv_q, rv_d, rb_q, rb_d;
  logic              push_q, push_d, x, hit;
  logic [PW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0] acc_q, acc_d, acc_n, pw_q, pw_d;
  spd_e              spd_q, spd_d;

  function automatic logic [PW-1:0] last_idx(input spd_e s);
    case (s)
      SPD_LOW: return PW'(WORD_W / 4 - 1);
      SPD_MID: return PW'(WORD_W / 2 - 1);
      default: return PW'(WORD_W - 1);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] align(input logic [WORD_W-1:0] a, input spd_e s);
    case (s)
      SPD_LOW: return a << (WORD_W - WORD_W / 4);
      SPD_MID: return a << (WORD_W - WORD_W / 2);
      default: return a;
    endcase
  endfunction

  always_comb begin
    x      = a_q ^ b_q;
    hit    = on_q && (x != px_q);
    px_d   = on_q ? x : 1'b0;
    spd_d  = (en && !on_q) ? spd_in : spd_q;
    rv_d   = hit;
    rb_d   = hit ? a_q : 1'b0;
    acc_n  = {acc_q[WORD_W-2:0], a_q};
    push_d = 1'b0;
    pw_d   = pw_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    if (!on_q) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (hit) begin
      if (cnt_q == last_idx(spd_q)) begin
        push_d = 1'b1;
        pw_d   = align(acc_n, spd_q);
        cnt_d  = '0;
        acc_d  = '0;
      end else begin
        cnt_d = cnt_q + PW'(1);
        acc_d = acc_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      on_q   <= 1'b0;
      px_q   <= 1'b0;
      rv_q   <= 1'b0;
      rb_q   <= 1'b0;
      push_q <= 1'b0;
      pw_q   <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
      spd_q  <= SPD_LOW;
    end else begin
      a_q    <= line_a;
      b_q    <= line_b;
      on_q   <= en;
      px_q   <= px_d;
      rv_q   <= rv_d;
      rb_q   <= rb_d;
      push_q <= push_d;
      pw_q   <= pw_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      spd_q  <= spd_d;
    end
  end

  assign rep_valid = rv_q;
  assign rep_bit   = rb_q;
  assign push      = push_q;
  assign push_word = pw_q;

endmodule

// File: rtl/ds_afifo.sv
module ds_afifo #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] wdata,
  output logic              full,
  input  logic              rclk,
  input  logic              rrst_n,
  output logic              rvalid,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0]       wbin_q, wbin_d, wgray_q, rg_s1, rg_s2;
  logic [AW:0]       rbin_q, rbin_d, rgray_q, wg_s1, wg_s2;
  logic              empty, wr_ok, rv_q;
  logic [WORD_W-1:0] rd_q, rd_d;

  always_comb begin
    full   = (wgray_q == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});
    wr_ok  = push && !full;
    wbin_d = wr_ok ? wbin_q + 1'b1 : wbin_q;
    empty  = (rgray_q == wg_s2);
    rbin_d = empty ? rbin_q : rbin_q + 1'b1;
    rd_d   = empty ? rd_q : mem[rbin_q[AW-1:0]];
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wbin_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      rg_s1   <= '0;
      rg_s2   <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
      rg_s1   <= rgray_q;
      rg_s2   <= rg_s1;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      wg_s1   <= '0;
      wg_s2   <= '0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
      wg_s1   <= wgray_q;
      wg_s2   <= wg_s1;
      rv_q    <= !empty;
      rd_q    <= rd_d;
    end
  end

  assign rvalid = rv_q;
  assign rdata  = rd_q;

endmodule

// File: rtl/ds_serdes.sv
module ds_serdes
  import ds_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int PW = $clog2(WORD_W)
) (
  input  logic              clk_bit,
  input  logic              clk_sys,
  input  logic              rst_n,
  input  logic              sys_tick,
  input  logic              tx_en,
  input  logic [1:0]        tx_speed,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_pair_a,
  output logic              tx_pair_b,
  output logic              tx_drive,
  input  logic              rx_en,
  input  logic [1:0]        rx_speed,
  input  logic              rx_pair_a,
  input  logic              rx_pair_b,
  output logic              rep_valid,
  output logic              rep_bit,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word
);

  logic [1:0]        rsb_q, rss_q;
  logic              rst_bit_n, rst_sys_n;
  logic              tx_act, tx_line_a, tx_line_b, rx_push, fifo_full;
  logic [PW-1:0]     tx_rem;
  logic [WORD_W-1:0] rx_pword;
  spd_e              tx_spd;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) rsb_q <= 2'b00;
    else        rsb_q <= {rsb_q[0], 1'b1};
  end

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) rss_q <= 2'b00;
    else        rss_q <= {rss_q[0], 1'b1};
  end

  assign rst_bit_n = rsb_q[1];
  assign rst_sys_n = rss_q[1];

  ds_tx #(.WORD_W(WORD_W)) u_tx (
    .clk        (clk_bit),
    .rst_n      (rst_bit_n),
    .tick       (sys_tick),
    .en         (tx_en),
    .spd_in     (spd_e'(tx_speed)),
    .word       (tx_data),
    .line_data  (tx_line_b),
    .line_strobe(tx_line_a),
    .active     (tx_act),
    .spd        (tx_spd),
    .rem        (tx_rem)
  );

  ds_rx #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk_bit),
    .rst_n    (rst_bit_n),
    .en       (rx_en),
    .spd_in   (spd_e'(rx_speed)),
    .line_a   (rx_pair_a),
    .line_b   (rx_pair_b),
    .rep_valid(rep_valid),
    .rep_bit  (rep_bit),
    .push     (rx_push),
    .push_word(rx_pword)
  );

  ds_afifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .wclk  (clk_bit),
    .wrst_n(rst_bit_n),
    .push  (rx_push),
    .wdata (rx_pword),
    .full  (fifo_full),
    .rclk  (clk_sys),
    .rrst_n(rst_sys_n),
    .rvalid(rx_valid),
    .rdata (rx_word)
  );

  assign tx_pair_a = tx_line_a;
  assign tx_pair_b = tx_line_b;
  assign tx_drive  = tx_act & ~rx_en;

endmodule

// File: rtl/ds_serdes_chk.sv
module ds_serdes_chk #(
  parameter int REM_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             act,
  input logic [1:0]       spd,
  input logic [REM_W-1:0] rem,
  input logic             line_a,
  input logic             line_b,
  input logic             push,
  input logic             full
);

  // R4: per bit only one of strobe/data may move while sending
  a_r4_one_line_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act)) |->
      ($countones({line_a ^ $past(line_a), line_b ^ $past(line_b)}) <= 1));

  // R5: latched speed constant inside a packet
  a_r5_speed_held: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act)) |-> (spd == $past(spd)));

  // R3: every bit of a word is out before the next word boundary
  a_r3_word_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act) |-> (rem == '0));

  // R12: the FIFO never receives a word while full
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

bind ds_serdes ds_serdes_chk #(.REM_W(PW)) u_chk (
  .clk   (clk_bit),
  .rst_n (rst_bit_n),
  .tick  (sys_tick),
  .act   (tx_act),
  .spd   (tx_spd),
  .rem   (tx_rem),
  .line_a(tx_line_a),
  .line_b(tx_line_b),
  .push  (rx_push),
  .full  (fifo_full)
);

// File: tb/ds_serdes_tb.sv
module ds_serdes_tb;
  localparam int CLK_PERIOD = 4;
  localparam int SYS_PERIOD = 8 * CLK_PERIOD - 2;

  logic clk_bit, clk_sys, rst_n, sys_tick, tx_en, rx_en, rx_pair_a, rx_pair_b;
  logic [1:0] tx_speed, rx_speed;
  logic [7:0] tx_data, rx_word;
  logic tx_pair_a, tx_pair_b, tx_drive, rep_valid, rep_bit, rx_valid;

  int n_chk = 0;
  int n_fail = 0;

  logic       m_act, m_dat, m_stb;
  logic [1:0] m_spd;
  logic [7:0] m_word;
  int         k;
  logic       exp_rep[$];
  logic [7:0] exp_word[$];
  logic       pd, ps;

  ds_serdes u_dut (
    .clk_bit(clk_bit), .clk_sys(clk_sys), .rst_n(rst_n), .sys_tick(sys_tick),
    .tx_en(tx_en), .tx_speed(tx_speed), .tx_data(tx_data),
    .tx_pair_a(tx_pair_a), .tx_pair_b(tx_pair_b), .tx_drive(tx_drive),
    .rx_en(rx_en), .rx_speed(rx_speed), .rx_pair_a(rx_pair_a), .rx_pair_b(rx_pair_b),
    .rep_valid(rep_valid), .rep_bit(rep_bit), .rx_valid(rx_valid), .rx_word(rx_word)
  );

  initial begin
    clk_bit = 1'b0;
    forever #(CLK_PERIOD / 2) clk_bit = ~clk_bit;
  end

  initial begin
    clk_sys = 1'b0;
    forever #(SYS_PERIOD / 2) clk_sys = ~clk_sys;
  end

  function automatic int nbits(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Transmit reference model and per-cycle comparison (R3, R4, R6, R7)
  always @(posedge clk_bit) begin
    if (!rst_n) begin
      m_act = 1'b0; m_dat = 1'b0; m_stb = 1'b0; m_spd = 2'd0; m_word = 8'h00; k = 0;
    end else begin
      if (sys_tick) begin
        k = 0;
        if (tx_en) begin
          if (!m_act) begin m_act = 1'b1; m_spd = tx_speed; end
          m_word = tx_data;
        end else begin
          m_act = 1'b0; m_dat = 1'b0; m_stb = 1'b0;
        end
      end else begin
        k++;
      end
      if (m_act) begin
        int n, st;
        logic b;
        n  = nbits(m_spd);
        st = 8 / n;
        if ((k % st == 0) && (k / st < n)) begin
          b = m_word[7 - k / st];
          if (b == m_dat) m_stb = ~m_stb;
          m_dat = b;
        end
      end
    end
    #1;
    chk("R3", {31'b0, tx_pair_b}, {31'b0, m_dat}, "data line");
    chk("R4", {31'b0, tx_pair_a}, {31'b0, m_stb}, "strobe line");
    chk("R7", {31'b0, tx_drive}, {31'b0, m_act & ~rx_en}, "tx_drive");
  end

  // Repeat stream check (R8)
  always @(posedge clk_bit) begin
    #1;
    if (rst_n && rep_valid) begin
      if (exp_rep.size() == 0) chk("R8", 32'd1, 32'd0, "unexpected rep_valid");
      else chk("R8", {31'b0, rep_bit}, {31'b0, exp_rep.pop_front()}, "rep_bit");
    end
  end

  // Received word check in system domain (R9, R12)
  always @(posedge clk_sys) begin
    #1;
    if (rst_n && rx_valid) begin
      if (exp_word.size() == 0) chk("R12", 32'd1, 32'd0, "unexpected rx_valid");
      else chk("R9", {24'b0, rx_word}, {24'b0, exp_word.pop_front()}, "rx_word");
    end
  end

  task automatic tx_period(input logic en, input logic [1:0] spd, input logic [7:0] d);
    @(negedge clk_bit);
    sys_tick = 1'b1; tx_en = en; tx_speed = spd; tx_data = d;
    @(negedge clk_bit);
    sys_tick = 1'b0;
    repeat (6) @(negedge clk_bit);
  endtask

  task automatic rx_send(input logic [1:0] spd, input logic [63:0] bits, input int nb,
                         input int chg_at, input logic [1:0] new_spd);
    int w, step, cnt;
    logic [7:0] acc;
    w = nbits(spd); step = 8 / w; cnt = 0; acc = 8'h00;
    pd = 1'b0; ps = 1'b0;
    @(negedge clk_bit);
    rx_en = 1'b1; rx_speed = spd; rx_pair_a = 1'b0; rx_pair_b = 1'b0;
    @(negedge clk_bit);
    for (int i = 0; i < nb; i++) begin
      logic b;
      @(negedge clk_bit);
      b = bits[nb - 1 - i];
      if (b == pd) ps = ~ps;
      pd = b;
      rx_pair_a = pd; rx_pair_b = ps;
      if (i == chg_at) rx_speed = new_spd;
      exp_rep.push_back(b);
      acc = {acc[6:0], b};
      cnt++;
      if (cnt == w) begin
        exp_word.push_back(acc << (8 - w));
        cnt = 0; acc = 8'h00;
      end
      repeat (step - 1) @(negedge clk_bit);
    end
    @(negedge clk_bit);
    rx_en = 1'b0; rx_pair_a = 1'b0; rx_pair_b = 1'b0;
    repeat (3) @(negedge clk_bit);
  endtask

  task automatic drain;
    repeat (40) @(negedge clk_bit);
    chk("R10", exp_word.size(), 32'd0, "words still expected");
    chk("R8", exp_rep.size(), 32'd0, "bits still expected");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sys_tick = 1'b0; tx_en = 1'b0; tx_speed = 2'd0; tx_data = 8'h00;
    rx_en = 1'b0; rx_speed = 2'd0; rx_pair_a = 1'b0; rx_pair_b = 1'b0;
    repeat (3) @(posedge clk_bit);
    #1;
    // R1: reset values
    chk("R1", {28'b0, tx_pair_a, tx_pair_b, tx_drive, rep_valid}, 32'd0, "tx/rep outputs");
    chk("R1", {31'b0, rx_valid}, 32'd0, "rx_valid");
    @(negedge clk_bit);
    rst_n = 1'b1;
    repeat (6) @(negedge clk_bit);

    // R2, R3: low speed, low bits of tx_data must not matter
    tx_period(1'b1, 2'd0, 8'h9F);
    tx_period(1'b1, 2'd0, 8'h40);
    tx_period(1'b1, 2'd0, 8'hC5);
    tx_period(1'b0, 2'd0, 8'h00); // R6
    tx_period(1'b0, 2'd0, 8'h00);
    // middle speed with repeated bits for strobe toggles (R4)
    tx_period(1'b1, 2'd1, 8'h3C);
    tx_period(1'b1, 2'd1, 8'hFF);
    tx_period(1'b1, 2'd1, 8'h0A);
    tx_period(1'b0, 2'd1, 8'h00);
    // R5: top speed, tx_speed changes mid packet
    tx_period(1'b1, 2'd2, 8'hA5);
    tx_period(1'b1, 2'd0, 8'h00);
    tx_period(1'b1, 2'd1, 8'hFF);
    tx_period(1'b1, 2'd0, 8'h96);
    tx_period(1'b0, 2'd0, 8'h00);
    // R2: code 3 behaves as top speed
    tx_period(1'b1, 2'd3, 8'h5B);
    tx_period(1'b0, 2'd3, 8'h00);

    // R8, R9: receive at each speed
    rx_send(2'd0, 64'h2D, 6, -1, 2'd0);
    drain();
    rx_send(2'd1, 64'hC3A, 12, -1, 2'd1);
    drain();
    rx_send(2'd2, 64'hA5FF00, 24, -1, 2'd2);
    drain();
    // R11: rx_speed changes after a few bits
    rx_send(2'd2, 64'h3C96, 16, 2, 2'd0);
    drain();
    // R10: packet ends two bits into the third word
    rx_send(2'd1, 64'h2B6, 10, -1, 2'd1);
    drain();

    // R7: receive while a transmit packet runs
    fork
      begin
        tx_period(1'b1, 2'd1, 8'hE1);
        tx_period(1'b1, 2'd1, 8'h7B);
        tx_period(1'b1, 2'd1, 8'h00);
        tx_period(1'b0, 2'd1, 8'h00);
      end
      begin
        repeat (5) @(negedge clk_bit);
        rx_send(2'd0, 64'h9, 4, -1, 2'd0);
      end
    join
    drain();

    repeat (10) @(negedge clk_bit);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule